// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns a 32-bit virtual address into a physical address. Pages are 4096 bytes. The low 12 address bits pass through unchanged as the page offset. The upper 20 bits are the virtual page number, and they are compared against every cached entry in a single parallel search. A hit returns the frame number of the matching entry joined to the offset. The hit is only granted after the present bit and the read/write/execute flags have been checked against the kind of access requested.

Each entry keeps a usage flag and a dirty flag. A granted access sets the usage flag, and a granted write also sets the dirty flag. An entry marked non-cacheable raises an uncached indication, so that a memory-mapped device access bypasses the data cache. When the search finds no valid match, the block reports a miss together with the page number. An external agent then walks the page table and writes the entry through a fill port. If a fill replaces a live entry, the block reports that entry's page number, usage flag and dirty flag, so the agent can write them back to the page table. A flush input empties the whole buffer in one cycle. The capacity is a parameter (8 to 64 entries).

Top module: `xlat_buffer`

## Requirements
- R1: When no valid entry matches the page number of a request, the response one cycle later has miss set, and rsp_vpn carries the requested page number.
- R2: A granted access gives a response one clock after the accepted request, with hit set and paddr equal to the entry's frame number concatenated with the 12 request offset bits.
- R3: The access kind is encoded as 00 read, 01 write, 10 fetch, and 11 is treated as read. A read needs the read flag, a write needs the write flag and a fetch needs the execute flag. A missing flag gives prot_fault with paddr zero, and the entry's usage and dirty flags are left unchanged.
- R4: A match on an entry whose present bit is clear gives page_fault, with no translation and no change to the usage and dirty flags.
- R5: A granted access sets the usage flag of its entry, and a granted write also sets the dirty flag. A fill clears both flags.
- R6: uncached is asserted on a granted access exactly when the entry was filled with its non-cacheable bit set.
- R7: Every response has exactly one of hit, miss, page_fault and prot_fault set.
- R8: A fill whose page number is already cached overwrites that entry. Otherwise the fill takes the lowest-numbered empty slot. When every slot is full, it takes a round-robin victim that starts at slot 0 and advances by one on each such replacement. One cycle after replacing a live entry, evict_valid pulses with that entry's page number, usage flag and dirty flag.
- R9: A flush invalidates every entry at the next edge. It takes priority over a fill in the same cycle, which is discarded.
- R10: A fill or flush in the same cycle as a request refuses the request: req_ready is low and no response follows, so the requester retries.
- R11: After reset the buffer is empty, and no response and no eviction report are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 read |
| fill_valid_i | input | 1 | Write an entry |
| fill_vpn_i | input | 20 | Page number of the entry |
| fill_pfn_i | input | 20 | Frame number of the entry |
| fill_present_i | input | 1 | Page resident in memory |
| fill_rd_i | input | 1 | Read allowed |
| fill_wr_i | input | 1 | Write allowed |
| fill_ex_i | input | 1 | Fetch allowed |
| fill_nocache_i | input | 1 | Bypass the data cache |
| rsp_valid_o | output | 1 | Response valid |
| rsp_hit_o | output | 1 | Granted translation |
| rsp_miss_o | output | 1 | No matching entry |
| rsp_page_fault_o | output | 1 | Matching entry not present |
| rsp_prot_fault_o | output | 1 | Access kind not permitted |
| rsp_uncached_o | output | 1 | Granted access bypasses the cache |
| rsp_paddr_o | output | 32 | Physical address (zero unless granted) |
| rsp_vpn_o | output | 20 | Page number of the request |
| evict_valid_o | output | 1 | A live entry was replaced |
| evict_vpn_o | output | 20 | Page number of the replaced entry |
| evict_used_o | output | 1 | Its usage flag |
| evict_dirty_o | output | 1 | Its dirty flag |

## Verification
The bench fills the buffer until it is full and then forces replacements. Reading the usage and dirty flags back through the eviction report shows whether a denied write, a denied fetch or a non-present hit wrongly marked its entry; a design that set the flags before checking permissions would report them set. Refilling a page that is already cached must not consume a slot or report an eviction; a design that skipped this check would hold duplicate tags or evict the wrong slot. A request that collides with a fill must produce no response at all, and a flush must turn the next lookup into a miss. A design that served the colliding lookup, or that left entries valid after the flush, would show a stray response or a false hit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic present;
    logic rd;
    logic wr;
    logic ex;
    logic nocache;
  } pte_attr_t;

  typedef struct packed {
    logic used;
    logic dirty;
  } pte_use_t;

endpackage

// File: rtl/xlat_prio_enc.sv
module xlat_prio_enc #(
  parameter  int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
  end

endmodule

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int N     = 16,
  parameter int TAG_W = 20
) (
  input  logic [N-1:0]     valid_i,
  input  logic [TAG_W-1:0] tags_i [N],
  input  logic [TAG_W-1:0] key_i,
  output logic [N-1:0]     match_o
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g] == key_i);
  end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter  int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance_i,
  output logic [IDX_W-1:0] ptr_o
);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (advance_i) begin
      if (ptr_q == IDX_W'(N - 1)) ptr_d = '0;
      else                        ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (advance_i) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter  int VA_W    = 32,
  parameter  int OFF_W   = 12,
  parameter  int PFN_W   = 20,
  parameter  int ENTRIES = 16,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             fill_present_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_ex_i,
  input  logic             fill_nocache_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic             rsp_miss_o,
  output logic             rsp_page_fault_o,
  output logic             rsp_prot_fault_o,
  output logic             rsp_uncached_o,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic [VPN_W-1:0] rsp_vpn_o,
  output logic             evict_valid_o,
  output logic [VPN_W-1:0] evict_vpn_o,
  output logic             evict_used_o,
  output logic             evict_dirty_o
);

  // entry storage
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [VPN_W-1:0]   vpn_d  [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [PFN_W-1:0]   pfn_d  [ENTRIES];
  pte_attr_t          attr_q [ENTRIES];
  pte_attr_t          attr_d [ENTRIES];
  pte_use_t           use_q  [ENTRIES];
  pte_use_t           use_d  [ENTRIES];

  // request side
  logic [VPN_W-1:0] req_vpn;
  logic [OFF_W-1:0] req_off;
  acc_kind_e        kind;
  logic             lookup_go, fill_go;

  assign req_vpn     = req_vaddr_i[VA_W-1:OFF_W];
  assign req_off     = req_vaddr_i[OFF_W-1:0];
  assign kind        = acc_kind_e'(req_kind_i);
  assign req_ready_o = !fill_valid_i && !flush_i;
  assign lookup_go   = req_valid_i && req_ready_o;
  assign fill_go     = fill_valid_i && !flush_i;

  // associative search for the lookup and for the fill
  logic [ENTRIES-1:0] l_match, f_match;
  logic [IDX_W-1:0]   hit_idx, fmatch_idx, free_idx, rr_idx;
  logic               hit_any, fmatch_any, free_any;

  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_cam_lookup (
    .valid_i(valid_q), .tags_i(vpn_q), .key_i(req_vpn), .match_o(l_match)
  );
  xlat_cam #(.N(ENTRIES), .TAG_W(VPN_W)) u_cam_fill (
    .valid_i(valid_q), .tags_i(vpn_q), .key_i(fill_vpn_i), .match_o(f_match)
  );
  xlat_prio_enc #(.N(ENTRIES)) u_enc_hit (
    .req_i(l_match), .idx_o(hit_idx), .any_o(hit_any)
  );
  xlat_prio_enc #(.N(ENTRIES)) u_enc_fmatch (
    .req_i(f_match), .idx_o(fmatch_idx), .any_o(fmatch_any)
  );
  xlat_prio_enc #(.N(ENTRIES)) u_enc_free (
    .req_i(~valid_q), .idx_o(free_idx), .any_o(free_any)
  );

  logic evict_go;
  assign evict_go = fill_go && !fmatch_any && !free_any;

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .advance_i(evict_go), .ptr_o(rr_idx)
  );

  logic [IDX_W-1:0] fill_idx;
  always_comb begin
    if (fmatch_any)    fill_idx = fmatch_idx;
    else if (free_any) fill_idx = free_idx;
    else               fill_idx = rr_idx;
  end

  // hit evaluation
  pte_attr_t        h_attr;
  logic             perm_ok;
  logic             miss_n, pgf_n, prot_n, ok_n, unc_n;
  logic [PA_W-1:0]  paddr_n;

  always_comb begin
    h_attr = attr_q[hit_idx];
    unique case (kind)
      ACC_WRITE: perm_ok = h_attr.wr;
      ACC_FETCH: perm_ok = h_attr.ex;
      default:   perm_ok = h_attr.rd;
    endcase
    miss_n  = !hit_any;
    pgf_n   = hit_any && !h_attr.present;
    prot_n  = hit_any && h_attr.present && !perm_ok;
    ok_n    = hit_any && h_attr.present && perm_ok;
    unc_n   = ok_n && h_attr.nocache;
    paddr_n = ok_n ? {pfn_q[hit_idx], req_off} : '0;
  end

  // table next state
  always_comb begin
    valid_d = valid_q;
    vpn_d   = vpn_q;
    pfn_d   = pfn_q;
    attr_d  = attr_q;
    use_d   = use_q;
    if (flush_i) begin
      valid_d = '0;
    end else if (fill_go) begin
      valid_d[fill_idx]        = 1'b1;
      vpn_d[fill_idx]          = fill_vpn_i;
      pfn_d[fill_idx]          = fill_pfn_i;
      attr_d[fill_idx].present = fill_present_i;
      attr_d[fill_idx].rd      = fill_rd_i;
      attr_d[fill_idx].wr      = fill_wr_i;
      attr_d[fill_idx].ex      = fill_ex_i;
      attr_d[fill_idx].nocache = fill_nocache_i;
      use_d[fill_idx]          = '0;
    end else if (lookup_go && ok_n) begin
      use_d[hit_idx].used = 1'b1;
      if (kind == ACC_WRITE) use_d[hit_idx].dirty = 1'b1;
    end
  end

  logic table_we;
  assign table_we = fill_go || (lookup_go && ok_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (table_we) begin
      vpn_q  <= vpn_d;
      pfn_q  <= pfn_d;
      attr_q <= attr_d;
      use_q  <= use_d;
    end
  end

  // response and eviction registers
  logic rsp_valid_q, evict_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q   <= 1'b0;
      evict_valid_q <= 1'b0;
    end else begin
      rsp_valid_q   <= lookup_go;
      evict_valid_q <= evict_go;
    end
  end

  always_ff @(posedge clk) begin
    if (lookup_go) begin
      rsp_hit_o        <= ok_n;
      rsp_miss_o       <= miss_n;
      rsp_page_fault_o <= pgf_n;
      rsp_prot_fault_o <= prot_n;
      rsp_uncached_o   <= unc_n;
      rsp_paddr_o      <= paddr_n;
      rsp_vpn_o        <= req_vpn;
    end
    if (evict_go) begin
      evict_vpn_o   <= vpn_q[rr_idx];
      evict_used_o  <= use_q[rr_idx].used;
      evict_dirty_o <= use_q[rr_idx].dirty;
    end
  end

  assign rsp_valid_o   = rsp_valid_q;
  assign evict_valid_o = evict_valid_q;

endmodule

// File: rtl/xlat_buffer_chk.sv
module xlat_buffer_chk #(
  parameter int OFF_W   = 12,
  parameter int PA_W    = 32,
  parameter int VA_W    = 32,
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush_i,
  input logic               fill_valid_i,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic [VA_W-1:0]    req_vaddr_i,
  input logic               rsp_valid_o,
  input logic               rsp_hit_o,
  input logic               rsp_miss_o,
  input logic               rsp_page_fault_o,
  input logic               rsp_prot_fault_o,
  input logic               rsp_uncached_o,
  input logic [PA_W-1:0]    rsp_paddr_o,
  input logic               evict_valid_o,
  input logic [ENTRIES-1:0] valid_q
);

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_miss_o, rsp_page_fault_o, rsp_prot_fault_o}) == 1);

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=>
      (!rsp_hit_o || rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0])));

  a_r6_uncached_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_uncached_o) |-> rsp_hit_o);

  a_r8_evict_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid_o |-> $past(fill_valid_i && !flush_i));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (valid_q == '0));

  a_r10_fill_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid_i || flush_i) |=> !rsp_valid_o);

endmodule

bind xlat_buffer xlat_buffer_chk #(
  .OFF_W(OFF_W), .PA_W(PA_W), .VA_W(VA_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fill_valid_i(fill_valid_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_vaddr_i(req_vaddr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
  .rsp_page_fault_o(rsp_page_fault_o), .rsp_prot_fault_o(rsp_prot_fault_o),
  .rsp_uncached_o(rsp_uncached_o), .rsp_paddr_o(rsp_paddr_o),
  .evict_valid_o(evict_valid_o), .valid_q(valid_q)
);

// File: tb/sim_xlat_buffer.sv
module sim_xlat_buffer;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, req_valid_i, fill_valid_i;
  logic        fill_present_i, fill_rd_i, fill_wr_i, fill_ex_i, fill_nocache_i;
  logic [31:0] req_vaddr_i;
  logic [1:0]  req_kind_i;
  logic [19:0] fill_vpn_i, fill_pfn_i;
  logic        req_ready_o, rsp_valid_o, rsp_hit_o, rsp_miss_o;
  logic        rsp_page_fault_o, rsp_prot_fault_o, rsp_uncached_o;
  logic [31:0] rsp_paddr_o;
  logic [19:0] rsp_vpn_o, evict_vpn_o;
  logic        evict_valid_o, evict_used_o, evict_dirty_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xlat_buffer #(.ENTRIES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_vaddr_i(req_vaddr_i), .req_kind_i(req_kind_i),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_pfn_i(fill_pfn_i),
    .fill_present_i(fill_present_i), .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i),
    .fill_ex_i(fill_ex_i), .fill_nocache_i(fill_nocache_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_miss_o(rsp_miss_o),
    .rsp_page_fault_o(rsp_page_fault_o), .rsp_prot_fault_o(rsp_prot_fault_o),
    .rsp_uncached_o(rsp_uncached_o), .rsp_paddr_o(rsp_paddr_o), .rsp_vpn_o(rsp_vpn_o),
    .evict_valid_o(evict_valid_o), .evict_vpn_o(evict_vpn_o),
    .evict_used_o(evict_used_o), .evict_dirty_o(evict_dirty_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // response word: {valid, hit, miss, pgf, prot, unc}
  function automatic logic [5:0] rsp_bits();
    return {rsp_valid_o, rsp_hit_o, rsp_miss_o, rsp_page_fault_o, rsp_prot_fault_o, rsp_uncached_o};
  endfunction

  task automatic lookup(input logic [31:0] va, input logic [1:0] kind);
    @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = va; req_kind_i = kind;
    @(posedge clk); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic p, input logic r, input logic w, input logic x, input logic nc);
    @(negedge clk);
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_pfn_i = pfn;
    fill_present_i = p; fill_rd_i = r; fill_wr_i = w; fill_ex_i = x; fill_nocache_i = nc;
    @(posedge clk); #1;
    fill_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 rsp_valid", rsp_valid_o, 0);
    chk("R11 evict_valid", evict_valid_o, 0);
    chk("R11 ready", req_ready_o, 1);
    lookup(32'h0000_0000, 2'b00);
    chk("R11 empty lookup misses", rsp_miss_o, 1);
  endtask

  task automatic t_miss();
    lookup(32'h1234_5678, 2'b00);
    chk("R1 miss flags", rsp_bits(), 6'b101000);
    chk("R1 miss vpn", rsp_vpn_o, 20'h12345);
  endtask

  task automatic t_hit_rw();
    fill(20'h12345, 20'hABCDE, 1, 1, 1, 0, 0);
    chk("R8 no evict into empty", evict_valid_o, 0);
    lookup(32'h1234_5678, 2'b00);
    chk("R2 read hit flags", rsp_bits(), 6'b110000);
    chk("R2 read paddr", rsp_paddr_o, 32'hABCD_E678);
    lookup(32'h1234_5FFF, 2'b01);
    chk("R2 write hit paddr", rsp_paddr_o, 32'hABCD_EFFF);
    lookup(32'h1234_5000, 2'b10);
    chk("R3 fetch without x", rsp_bits(), 6'b100010);
    chk("R3 denied paddr zero", rsp_paddr_o, 0);
    lookup(32'h1234_5004, 2'b11);
    chk("R3 kind 11 acts as read", rsp_bits(), 6'b110000);
  endtask

  task automatic t_prot();
    fill(20'h00100, 20'h00111, 1, 1, 0, 0, 0);
    lookup(32'h0010_0010, 2'b01);
    chk("R3 write without w", rsp_bits(), 6'b100010);
    lookup(32'h0010_0010, 2'b10);
    chk("R3 fetch without x", rsp_bits(), 6'b100010);
  endtask

  task automatic t_pgfault();
    fill(20'h00200, 20'h00222, 0, 1, 1, 1, 0);
    lookup(32'h0020_0ABC, 2'b00);
    chk("R4 non-present", rsp_bits(), 6'b100100);
    chk("R4 no translation", rsp_paddr_o, 0);
  endtask

  task automatic t_uncached();
    fill(20'h00300, 20'h0F00D, 1, 1, 0, 0, 1);
    lookup(32'h0030_0044, 2'b00);
    chk("R6 uncached hit", rsp_bits(), 6'b110001);
    chk("R6 uncached paddr", rsp_paddr_o, 32'h0F00_D044);
  endtask

  task automatic t_collide();
    @(negedge clk);
    req_valid_i = 1'b1; req_vaddr_i = 32'h0040_0123; req_kind_i = 2'b00;
    fill_valid_i = 1'b1; fill_vpn_i = 20'h00400; fill_pfn_i = 20'h44444;
    fill_present_i = 1; fill_rd_i = 1; fill_wr_i = 1; fill_ex_i = 1; fill_nocache_i = 0;
    #1;
    chk("R10 ready low on fill", req_ready_o, 0);
    @(posedge clk); #1;
    fill_valid_i = 1'b0; req_valid_i = 1'b0;
    @(posedge clk); #1;
    chk("R10 no response", rsp_valid_o, 0);
    lookup(32'h0040_0123, 2'b10);
    chk("R10 retry hits", rsp_bits(), 6'b110000);
    chk("R10 retry paddr", rsp_paddr_o, 32'h4444_4123);
  endtask

  task automatic t_replace();
    fill(20'h00500, 20'h00555, 1, 1, 1, 1, 0);
    fill(20'h00600, 20'h00666, 1, 1, 1, 1, 0);
    fill(20'h00700, 20'h00777, 1, 1, 1, 1, 0);
    chk("R8 last free slot no evict", evict_valid_o, 0);
    fill(20'h00700, 20'h07070, 1, 1, 1, 1, 0);
    chk("R8 refill same page no evict", evict_valid_o, 0);
    lookup(32'h0070_0001, 2'b00);
    chk("R8 refill new frame", rsp_paddr_o, 32'h0707_0001);
    fill(20'h00800, 20'h00888, 1, 1, 1, 1, 0);
    chk("R8 evict slot0", {evict_valid_o, evict_vpn_o}, {1'b1, 20'h12345});
    chk("R5 slot0 used+dirty", {evict_used_o, evict_dirty_o}, 2'b11);
    fill(20'h00900, 20'h00999, 1, 1, 1, 1, 0);
    chk("R8 evict slot1", {evict_valid_o, evict_vpn_o}, {1'b1, 20'h00100});
    chk("R3 denied left flags clear", {evict_used_o, evict_dirty_o}, 2'b00);
    lookup(32'h1234_5000, 2'b00);
    chk("R1 evicted page misses", rsp_bits(), 6'b101000);
    fill(20'h00A00, 20'h00AAA, 1, 1, 1, 1, 0);
    chk("R4 pgfault left flags clear", {evict_valid_o, evict_vpn_o, evict_used_o, evict_dirty_o},
        {1'b1, 20'h00200, 2'b00});
    fill(20'h00B00, 20'h00BBB, 1, 1, 1, 1, 0);
    chk("R5 read sets used only", {evict_vpn_o, evict_used_o, evict_dirty_o},
        {20'h00300, 2'b10});
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush_i = 1'b1; req_valid_i = 1'b1; req_vaddr_i = 32'h0050_0000; req_kind_i = 2'b00;
    fill_valid_i = 1'b1; fill_vpn_i = 20'h00C00; fill_pfn_i = 20'h00CCC;
    #1;
    chk("R9 ready low on flush", req_ready_o, 0);
    @(posedge clk); #1;
    flush_i = 1'b0; req_valid_i = 1'b0; fill_valid_i = 1'b0;
    chk("R9 flush drops fill", evict_valid_o, 0);
    lookup(32'h0050_0000, 2'b00);
    chk("R9 flushed entry misses", rsp_bits(), 6'b101000);
    lookup(32'h00C0_0000, 2'b00);
    chk("R9 discarded fill misses", rsp_miss_o, 1);
    for (int i = 0; i < N; i++) begin
      fill(20'h01000 + 20'(i), 20'h02000 + 20'(i), 1, 1, 1, 1, 0);
      chk("R8 refilled after flush no evict", evict_valid_o, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; flush_i = 0; req_valid_i = 0; fill_valid_i = 0;
    req_vaddr_i = '0; req_kind_i = '0; fill_vpn_i = '0; fill_pfn_i = '0;
    fill_present_i = 0; fill_rd_i = 0; fill_wr_i = 0; fill_ex_i = 0; fill_nocache_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_miss();
    t_hit_rw();
    t_prot();
    t_pgfault();
    t_uncached();
    t_collide();
    t_replace();
    t_flush();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule